// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port for a small microcontroller. Software reaches it through a simple register bus: an address, a write strobe, write data and combinational read data. Per pin, a direction bit picks between driving and receiving. The output-data bit is the driven level when the pin is an output. When the pin is an input, the same bit switches on a weak pull-up instead. The block produces an output value, an output enable and a pull-up enable for every pad.

Each pin input passes through a synchronizer, and the block then compares consecutive samples. A per-pin polarity bit chooses whether a rising or a falling transition counts. A counted transition sets a sticky flag. A single level interrupt request is raised while any flag is set and its enable bit is on.

A peripheral such as a PWM can take over any pin through a per-pin override. While the override is active, the peripheral's value and enable reach the pad, and the direction and output-data bits are bypassed. Edge detection continues on that pin, so peripheral activity can still raise interrupts.

Top module: `gpio_edge_port`

## Requirements
- R1: A pin in GPIO mode with direction bit 1 has `pin_oe`=1 and drives `pin_out` equal to its output-data bit, with `pin_pu`=0.
- R2: A pin in GPIO mode with direction bit 0 has `pin_oe`=0, and `pin_pu` equals its output-data bit (1 = pull-up on, 0 = high-impedance).
- R3: After reset the direction register reads 0x00, output-data reads 0xFF, and polarity, flag and enable registers read 0x00.
- R4: Writing the direction register leaves the stored output-data value unchanged.
- R5: Polarity bit 0 makes a pin flag on a low-to-high transition only. Polarity bit 1 makes it flag on a high-to-low transition only.
- R6: A flag, once set, stays set until a bus write to the flag register stores 0 in it, or reset. A write to the flag register stores the written value.
- R7: `irq` is 1 exactly when some bit is 1 in both the flag and enable registers, and it remains 1 while such a pair persists.
- R8: Edge detection and flagging operate identically whether or not the pin's override is active.
- R9: With `alt_sel[i]`=1, `pin_out[i]`=`alt_out[i]`, `pin_oe[i]`=`alt_oe[i]` and `pin_pu[i]`=0, whatever the direction and output-data bits hold.
- R10: A pin change applied before rising edge k is visible in the flag register after edge k+2 and not after edge k+1 (two synchronizer flops plus one previous-sample flop).
- R11: If a flag-register write and a detected edge on the same pin fall on the same clock edge, the flag ends up set.
- R12: The register map uses address 0 for direction, 1 for output-data, 2 for polarity, 3 for flags, 4 for enables, and 5 for the synchronized pin levels (read-only; writes are ignored). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pad input levels, asynchronous |
| alt_sel | input | NUM_PINS | Per-pin peripheral override select |
| alt_out | input | NUM_PINS | Peripheral output value per pin |
| alt_oe | input | NUM_PINS | Peripheral output enable per pin |
| pin_out | output | NUM_PINS | Pad output value |
| pin_oe | output | NUM_PINS | Pad output enable |
| pin_pu | output | NUM_PINS | Pad weak pull-up enable |
| irq | output | 1 | Level interrupt request |

## Verification
Some properties are checked on every cycle: the override routing onto the pad, the stored output data holding across direction writes, flag stickiness without a flag write, the set winning over a same-cycle clear, the request holding without bus writes, and the reset register values. Other behaviour needs the bench's scenarios to show it, because it depends on a stimulus history. This covers the polarity choice, the exact three-edge latency from a pin change to a flag, detection while the override is active, and the read-back of the map, including the ignored write to the level register.

// File: rtl/gpio_edge_pkg.sv
// Package: register map shared by the port and its checker.
// Assumes the address bus is at least three bits wide.
package gpio_edge_pkg;
    localparam int REG_DIR   = 0;  // direction, 1 = drive
    localparam int REG_DATA  = 1;  // output data / pull-up select
    localparam int REG_POL   = 2;  // edge polarity, 1 = falling
    localparam int REG_FLAG  = 3;  // sticky edge flags
    localparam int REG_EN    = 4;  // interrupt enables
    localparam int REG_LEVEL = 5;  // synchronized pin levels, read-only
endpackage

// File: rtl/gpio_edge_sync.sv
// Module: synchronizes the asynchronous pin levels and finds the qualifying
// edges on them. Assumes that reset holds all stages at 0, so a pin that is
// high when reset is released reports one rising transition.
module gpio_edge_sync #(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    input  logic [NUM_PINS-1:0] pol_fall,
    output logic [NUM_PINS-1:0] level,
    output logic [NUM_PINS-1:0] edge_hit
);
    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
    logic [NUM_PINS-1:0] prev_q;

    // First synchronizer flop captures the raw pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pin_async;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            // Further flops shift the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    // Keep the previous synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[SYNC_STAGES-1];
    end

    assign level = stage_q[SYNC_STAGES-1];

    // Select rising or falling transitions per pin.
    always_comb begin
        edge_hit = (pol_fall & prev_q & ~level) | (~pol_fall & ~prev_q & level);
    end
endmodule

// File: rtl/gpio_pad_mux.sv
// Module: builds the pad controls per pin. GPIO mode uses the direction and
// data bits. Override mode hands the pad to the peripheral, with the
// pull-up off. Assumes the override inputs are already synchronous.
module gpio_pad_mux #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] data,
    input  logic [NUM_PINS-1:0] alt_sel,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_pu
);
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            // Choose the pad controls for one pin.
            always_comb begin
                if (alt_sel[i]) begin
                    pad_out[i] = alt_out[i];
                    pad_oe[i]  = alt_oe[i];
                    pad_pu[i]  = 1'b0;
                end else begin
                    pad_out[i] = data[i];
                    pad_oe[i]  = dir[i];
                    pad_pu[i]  = ~dir[i] & data[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_port.sv
// Module: top of the GPIO port. It holds the register file, decodes bus
// accesses, keeps the sticky edge flags and forms the interrupt request.
// Assumes single-cycle writes and combinational reads.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] alt_sel,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_pu,
    output logic                irq
);
    logic [NUM_PINS-1:0] dir_q, data_q, pol_q, flag_q, en_q;
    logic [NUM_PINS-1:0] level, edge_hit;
    logic wr_dir, wr_data, wr_pol, wr_flag, wr_en;

    // Decode which register a bus write targets.
    always_comb begin
        wr_dir  = bus_wr_en && (bus_addr == ADDR_W'(REG_DIR));
        wr_data = bus_wr_en && (bus_addr == ADDR_W'(REG_DATA));
        wr_pol  = bus_wr_en && (bus_addr == ADDR_W'(REG_POL));
        wr_flag = bus_wr_en && (bus_addr == ADDR_W'(REG_FLAG));
        wr_en   = bus_wr_en && (bus_addr == ADDR_W'(REG_EN));
    end

    // Configuration registers: direction, data, polarity, enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '1;
            pol_q  <= '0;
            en_q   <= '0;
        end else begin
            if (wr_dir)  dir_q  <= bus_wdata;
            if (wr_data) data_q <= bus_wdata;
            if (wr_pol)  pol_q  <= bus_wdata;
            if (wr_en)   en_q   <= bus_wdata;
        end
    end

    // Sticky flags: a detected edge wins over a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (wr_flag ? bus_wdata : flag_q) | edge_hit;
    end

    // Return the addressed register, with 0 for unmapped addresses.
    always_comb begin
        unique case (int'(bus_addr))
            REG_DIR:   bus_rdata = dir_q;
            REG_DATA:  bus_rdata = data_q;
            REG_POL:   bus_rdata = pol_q;
            REG_FLAG:  bus_rdata = flag_q;
            REG_EN:    bus_rdata = en_q;
            REG_LEVEL: bus_rdata = level;
            default:   bus_rdata = '0;
        endcase
    end

    // Level request from any enabled, pending flag.
    assign irq = |(flag_q & en_q);

    gpio_edge_sync #(
        .NUM_PINS   (NUM_PINS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(pin_in),
        .pol_fall (pol_q),
        .level    (level),
        .edge_hit (edge_hit)
    );

    gpio_pad_mux #(
        .NUM_PINS(NUM_PINS)
    ) u_pad (
        .dir    (dir_q),
        .data   (data_q),
        .alt_sel(alt_sel),
        .alt_out(alt_out),
        .alt_oe (alt_oe),
        .pad_out(pin_out),
        .pad_oe (pin_oe),
        .pad_pu (pin_pu)
    );
endmodule

// File: rtl/gpio_edge_port_chk.sv
// Module: assertion checker bound to the GPIO port. It watches the bus,
// the pad outputs and the internal register state.
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr_en,
    input logic [NUM_PINS-1:0] alt_sel,
    input logic [NUM_PINS-1:0] alt_out,
    input logic [NUM_PINS-1:0] alt_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_pu,
    input logic                irq,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] data_q,
    input logic [NUM_PINS-1:0] flag_q,
    input logic [NUM_PINS-1:0] edge_hit
);
    logic flag_wr, dir_wr;
    assign flag_wr = bus_wr_en && (bus_addr == ADDR_W'(REG_FLAG));
    assign dir_wr  = bus_wr_en && (bus_addr == ADDR_W'(REG_DIR));

    // R3: register reset values on the first cycle out of reset.
    p_reset_values_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && data_q == '1 && flag_q == '0));

    // R4: a direction write keeps the output data.
    p_dir_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> $stable(data_q));

    // R6: flags stay set without a flag-register write.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R11: a detected edge always sets its flag, even against a clear.
    p_edge_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

    // R7: the request holds while no bus write can clear it.
    p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr_en) |=> irq);

    // R9: the override owns the pad outputs and turns off the pull-up.
    p_alt_owns_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_out ^ alt_out) | (pin_oe ^ alt_oe) | pin_pu) & alt_sel) == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr_en(bus_wr_en),
    .alt_sel  (alt_sel),
    .alt_out  (alt_out),
    .alt_oe   (alt_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu),
    .irq      (irq),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .flag_q   (flag_q),
    .edge_hit (edge_hit)
);

// File: tb/gpio_edge_port_bench.sv
// Bench: directed corner cases plus seeded random traffic, checked against a
// bench-side register model.
module gpio_edge_port_bench;
    localparam int N = 8;
    localparam int AW = 3;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr_en = 0;
    logic [N-1:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pin_in = '0, alt_sel = '0, alt_out = '0, alt_oe = '0;
    logic [N-1:0] pin_out, pin_oe, pin_pu;
    logic irq;

    int errors = 0, checks = 0;
    bit done = 0;

    // bench model
    logic [N-1:0] m_dir, m_data, m_pol, m_flag, m_en, m_pins;

    gpio_edge_port #(.NUM_PINS(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_gpio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [N-1:0] exp_out(input logic [N-1:0] d, a, ao);
        return (a & ao) | (~a & d);
    endfunction
    function automatic logic [N-1:0] exp_oe(input logic [N-1:0] dr, a, aoe);
        return (a & aoe) | (~a & dr);
    endfunction
    function automatic logic [N-1:0] exp_pu(input logic [N-1:0] dr, d, a);
        return ~a & ~dr & d;
    endfunction
    function automatic logic [N-1:0] exp_edges(input logic [N-1:0] oldv, newv, pol);
        return (pol & oldv & ~newv) | (~pol & ~oldv & newv);
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
        case (a)
            0: m_dir = d;
            1: m_data = d;
            2: m_pol = d;
            3: m_flag = d;
            4: m_en = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input int a, output logic [N-1:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req);
        #1;
        check({req, " pin_out"}, pin_out, exp_out(m_data, alt_sel, alt_out));
        check({req, " pin_oe"},  pin_oe,  exp_oe(m_dir, alt_sel, alt_oe));
        check({req, " pin_pu"},  pin_pu,  exp_pu(m_dir, m_data, alt_sel));
    endtask

    // Drive new pins at a negedge and let them pass through to the flags.
    task automatic apply_pins(input logic [N-1:0] v);
        @(negedge clk);
        m_flag = m_flag | exp_edges(m_pins, v, m_pol);
        m_pins = v;
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rd;
        void'($urandom(32'h5eed_1234));
        m_dir = '0; m_data = '1; m_pol = '0; m_flag = '0; m_en = '0; m_pins = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R3 reset values
        bus_read(0, rd); check("R3 dir reset", rd, 8'h00);
        bus_read(1, rd); check("R3 data reset", rd, 8'hFF);
        bus_read(2, rd); check("R3 pol reset", rd, 8'h00);
        bus_read(3, rd); check("R3 flag reset", rd, 8'h00);
        bus_read(4, rd); check("R3 en reset", rd, 8'h00);
        check_pads("R2 reset pads");

        // R1 / R2 pad controls
        bus_write(1, 8'hA5);
        bus_write(0, 8'h0F);
        check_pads("R1 R2 mixed dir");
        // R4 direction change keeps the data
        bus_write(0, 8'hF0);
        bus_read(1, rd); check("R4 data after dir write", rd, 8'hA5);

        // R12 map: level register read-only, unmapped read zero
        bus_write(5, 8'h3C);
        bus_read(5, rd); check("R12 level ignores write", rd, 8'h00);
        bus_read(6, rd); check("R12 unmapped reads zero", rd, 8'h00);
        bus_read(2, rd); check("R12 pol after level write", rd, 8'h00);

        // R10 latency and R5 rising polarity on pin 0
        @(negedge clk);
        pin_in = 8'h01;
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_read(3, rd); check("R10 flag not yet after 2 edges", rd, 8'h00);
        @(negedge clk);
        bus_read(3, rd); check("R10 R5 rising flag after 3 edges", rd, 8'h01);
        m_pins = 8'h01; m_flag = 8'h01;
        bus_read(5, rd); check("R12 level reads pins", rd, 8'h01);

        // R5 falling edge with polarity 0 is ignored
        bus_write(3, 8'h00);
        apply_pins(8'h00);
        bus_read(3, rd); check("R5 fall ignored when rising selected", rd, 8'h00);
        // R5 falling polarity
        bus_write(2, 8'h02);
        apply_pins(8'h02);
        bus_read(3, rd); check("R5 rise ignored when falling selected", rd, 8'h00);
        apply_pins(8'h00);
        bus_read(3, rd); check("R5 falling flag", rd, 8'h02);

        // R7 irq gating
        #1 check("R7 irq off when disabled", {7'b0, irq}, 8'h00);
        bus_write(4, 8'h02);
        #1 check("R7 irq on when enabled", {7'b0, irq}, 8'h01);
        repeat (5) @(negedge clk);
        check("R7 irq holds", {7'b0, irq}, 8'h01);
        // R6 sticky, then cleared by writing 0
        bus_read(3, rd); check("R6 flag sticky", rd, 8'h02);
        bus_write(3, 8'h00);
        bus_read(3, rd); check("R6 flag cleared", rd, 8'h00);
        #1 check("R7 irq drops", {7'b0, irq}, 8'h00);

        // R11 same-cycle clear and edge on pin 1 (falling selected)
        @(negedge clk);
        pin_in = 8'h02;   // rising: ignored
        repeat (4) @(negedge clk);
        pin_in = 8'h00;   // falling: detected
        @(posedge clk); @(posedge clk); @(negedge clk);
        bus_addr = AW'(3); bus_wdata = 8'h00; bus_wr_en = 1;
        @(negedge clk);
        bus_wr_en = 0;
        m_pins = 8'h00;
        bus_read(3, rd); check("R11 set wins over clear", rd, 8'h02);
        m_flag = 8'h02;

        // R8 / R9 override mode
        alt_sel = 8'h04; alt_out = 8'h04; alt_oe = 8'h00;
        bus_write(0, 8'h04);
        bus_write(1, 8'h00);
        check_pads("R9 override pads");
        bus_write(2, 8'h00);
        apply_pins(8'h04);
        bus_read(3, rd); check("R8 edge in override mode", rd, 8'h06);

        // Random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op == 5) begin
                alt_sel = N'($urandom); alt_out = N'($urandom); alt_oe = N'($urandom);
                #1;
            end else if (op == 3) begin
                bus_write(3, m_flag & N'($urandom));
            end else begin
                bus_write(op, N'($urandom));
            end
            check_pads("R1 R2 R9 random pads");
            apply_pins(N'($urandom));
            bus_read(3, rd); check("R5 R6 R8 random flags", rd, m_flag);
            check("R7 random irq", {7'b0, irq}, {7'b0, |(m_flag & m_en)});
            bus_read(0, rd); check("R12 random dir", rd, m_dir);
            bus_read(1, rd); check("R4 random data", rd, m_data);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule